// File: doc/BRIEF.md
# Paged Indirect Switch Register Accessor

This block lets a client read a register of an Ethernet switch whose register file is not mapped onto the management bus directly. The switch exposes its registers in 256-entry pages through one pseudo-PHY address. To reach a register, the block selects the page, writes an address/command word, polls that word until the switch reports the operation finished, and then fetches the result from one or two data registers. The block performs this whole sequence for one client request and returns either the data with a done pulse or an error pulse when the switch stays busy too long.

On the client side, a request carries a page number, a register number, a read/write flag and a width flag (16 or 32 bits). The request is held until the block acknowledges it. On the management side, the block issues single clause-22 register transactions to a frame master through a valid/done handshake. The serial bit engine sits behind that handshake and is not part of this block. The block remembers the last page it selected, so consecutive accesses within one page cost one fewer management transaction.

Top module: `swreg_indirect_access`

## Requirements
- R1: Every management transaction addresses PHY `PHY_ADDR` (default 5'h1E) on `mg_phy`.
- R2: A page select is a write to register 5'h10 whose data is the page number in bits 15:8, zero in bits 7:1 and 1 in bit 0.
- R3: The page select is issued only when the requested page differs from the remembered page, and it updates the remembered page. After reset the remembered page is 8'hFF: a first request to any other page writes the page, and a first request to page 8'hFF does not.
- R4: The command is a write to register 5'h11 with the register number in bits 15:8, zero in bits 7:2 and the opcode in bits 1:0 (2'b01 write, 2'b10 read). It follows the page select when one is issued, and otherwise it is the first transaction.
- R5: After the command, register 5'h11 is read until bits 1:0 are both zero. Each poll that returns busy is followed by a wait of `CYC_PER_US*WAIT_US` clock cycles before the next transaction.
- R6: If `MAX_POLLS` (default 5) polls all return busy, the request ends with a one-cycle `rsp_err`, `rsp_data` equal to zero, and no data-register read.
- R7: A 16-bit read fetches register 5'h18 once and returns it in `rsp_data[15:0]` with the upper half zero.
- R8: A 32-bit read fetches register 5'h18 and then register 5'h19 and returns {reg 5'h19, reg 5'h18}.
- R9: A write request ends with `rsp_done` after the first idle poll, issues no data-register read and returns `rsp_data` equal to zero.
- R10: `req_ack` is high only while the block is idle and `req_valid` is high. `rsp_done` and `rsp_err` are single-cycle pulses that never coincide. A request held through a whole access is acknowledged again only in the cycle in which the first request completes.
- R11: `mg_valid` stays high, with `mg_write`, `mg_regnum` and `mg_wdata` unchanged, until the cycle in which `mg_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client request present |
| req_page | input | 8 | Page of the target register |
| req_reg | input | 8 | Register number within the page |
| req_write | input | 1 | 1 issues the write opcode, 0 a read |
| req_wide | input | 1 | 1 for a 32-bit read, 0 for 16-bit |
| req_ack | output | 1 | Request accepted this cycle |
| rsp_done | output | 1 | One-cycle pulse: access finished |
| rsp_err | output | 1 | One-cycle pulse: busy timeout |
| rsp_data | output | 32 | Read result, valid with rsp_done |
| mg_valid | output | 1 | Management transaction requested |
| mg_write | output | 1 | 1 write, 0 read |
| mg_phy | output | 5 | PHY address of the transaction |
| mg_regnum | output | 5 | Clause-22 register number |
| mg_wdata | output | 16 | Write data |
| mg_done | input | 1 | Transaction complete (one cycle) |
| mg_rdata | input | 16 | Read data, valid with mg_done |

## Verification
The hardest paths to reach are the busy-poll loop and its timeout, because they depend on the switch answering "still busy" several times in a row. The bench's management model holds a programmable count of busy answers. Small counts exercise the wait between polls, where the gap from one poll's completion to the next poll's start is measured. A count larger than the poll limit drives the error path. A second hard case is the page cache state right after reset. A reset issued in the middle of the bench, followed by a request to page 8'hFF, shows that the page write is skipped. Holding `req_valid` high across a whole access shows when the second acknowledge may appear.

// File: rtl/swacc_pkg.sv
package swacc_pkg;

    localparam int PAGE_W  = 8;
    localparam int REGSEL_W = 8;
    localparam int MDW     = 16;

    localparam logic [4:0] REG_PAGE_SEL = 5'h10;
    localparam logic [4:0] REG_ADDR_CMD = 5'h11;
    localparam logic [4:0] REG_DATA_LO  = 5'h18;
    localparam logic [4:0] REG_DATA_HI  = 5'h19;

    localparam logic [1:0] OPC_WRITE = 2'd1;
    localparam logic [1:0] OPC_READ  = 2'd2;

    localparam logic [PAGE_W-1:0] PAGE_AFTER_RESET = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAGE,
        ST_CMD,
        ST_POLL,
        ST_WAIT,
        ST_RDLO,
        ST_RDHI
    } seq_state_e;

    typedef struct packed {
        logic [PAGE_W-1:0]   page;
        logic [REGSEL_W-1:0] regn;
        logic                is_write;
        logic                wide;
    } acc_req_t;

    typedef struct packed {
        logic           wr;
        logic [4:0]     regnum;
        logic [MDW-1:0] wdata;
    } mg_txn_t;

    function automatic logic [MDW-1:0] page_word(input logic [PAGE_W-1:0] p);
        return {p, 7'b0, 1'b1};
    endfunction

    function automatic logic [MDW-1:0] cmd_word(input logic [REGSEL_W-1:0] r,
                                                input logic is_wr);
        return {r, 6'b0, (is_wr ? OPC_WRITE : OPC_READ)};
    endfunction

    function automatic logic cmd_busy(input logic [MDW-1:0] v);
        return |v[1:0];
    endfunction

endpackage

// File: rtl/swacc_page_cache.sv
module swacc_page_cache
    import swacc_pkg::*;
#(
    parameter logic [PAGE_W-1:0] RESET_PAGE = PAGE_AFTER_RESET
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PAGE_W-1:0] probe_page,
    input  logic              upd,
    input  logic [PAGE_W-1:0] upd_page,
    output logic              hit
);

    logic [PAGE_W-1:0] cur_page;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_page <= RESET_PAGE;
        end else if (upd) begin
            cur_page <= upd_page;
        end
    end

    assign hit = (probe_page == cur_page);

endmodule

// File: rtl/swacc_wait_timer.sv
module swacc_wait_timer #(
    parameter int WAIT_CYC = 2500
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic expired
);

    localparam int CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic             active;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (start) begin
            cnt    <= CNT_W'(WAIT_CYC - 1);
            active <= 1'b1;
        end else if (active) begin
            if (cnt == '0) begin
                active <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign expired = active && (cnt == '0);

endmodule

// File: rtl/swacc_rdata_collect.sv
module swacc_rdata_collect
    import swacc_pkg::*;
#(
    parameter int HALF_W = MDW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic [HALF_W-1:0] din,
    output logic [2*HALF_W-1:0] dout
);

    logic [HALF_W-1:0] half_q [2];

    for (genvar g = 0; g < 2; g++) begin : g_half
        logic cap;
        assign cap = (g == 0) ? cap_lo : cap_hi;
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                half_q[g] <= '0;
            end else if (cap) begin
                half_q[g] <= din;
            end
        end
    end

    assign dout = {half_q[1], half_q[0]};

endmodule

// File: rtl/swacc_sequencer.sv
module swacc_sequencer
    import swacc_pkg::*;
#(
    parameter int MAX_POLLS = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  acc_req_t req_in,
    output logic     req_ack,
    input  logic     page_hit,
    output logic     cache_upd,
    output logic [PAGE_W-1:0] cache_page,
    output logic     timer_start,
    input  logic     timer_expired,
    output logic     mg_valid,
    output mg_txn_t  mg_txn,
    input  logic     mg_done,
    input  logic     mg_busy,
    output logic     cap_clr,
    output logic     cap_lo,
    output logic     cap_hi,
    output logic     rsp_done,
    output logic     rsp_err
);

    localparam int PCW = $clog2(MAX_POLLS + 1);

    seq_state_e       state;
    acc_req_t         cur;
    logic [PCW-1:0]   polls;

    // transaction presented to the management master, derived from state
    always_comb begin
        mg_valid = 1'b0;
        mg_txn   = '0;
        unique case (state)
            ST_PAGE: begin
                mg_valid     = 1'b1;
                mg_txn.wr    = 1'b1;
                mg_txn.regnum = REG_PAGE_SEL;
                mg_txn.wdata = page_word(cur.page);
            end
            ST_CMD: begin
                mg_valid     = 1'b1;
                mg_txn.wr    = 1'b1;
                mg_txn.regnum = REG_ADDR_CMD;
                mg_txn.wdata = cmd_word(cur.regn, cur.is_write);
            end
            ST_POLL: begin
                mg_valid      = 1'b1;
                mg_txn.regnum = REG_ADDR_CMD;
            end
            ST_RDLO: begin
                mg_valid      = 1'b1;
                mg_txn.regnum = REG_DATA_LO;
            end
            ST_RDHI: begin
                mg_valid      = 1'b1;
                mg_txn.regnum = REG_DATA_HI;
            end
            default: ;
        endcase
    end

    assign req_ack     = (state == ST_IDLE) && req_valid;
    assign cap_clr     = req_ack;
    assign cache_upd   = (state == ST_PAGE) && mg_done;
    assign cache_page  = cur.page;
    assign timer_start = (state == ST_POLL) && mg_done && mg_busy;
    assign cap_lo      = (state == ST_RDLO) && mg_done;
    assign cap_hi      = (state == ST_RDHI) && mg_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur      <= '0;
            polls    <= '0;
            rsp_done <= 1'b0;
            rsp_err  <= 1'b0;
        end else begin
            rsp_done <= 1'b0;
            rsp_err  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur   <= req_in;
                        polls <= '0;
                        state <= page_hit ? ST_CMD : ST_PAGE;
                    end
                end
                ST_PAGE: begin
                    if (mg_done) state <= ST_CMD;
                end
                ST_CMD: begin
                    if (mg_done) state <= ST_POLL;
                end
                ST_POLL: begin
                    if (mg_done) begin
                        polls <= polls + 1'b1;
                        if (mg_busy) begin
                            state <= ST_WAIT;
                        end else if (cur.is_write) begin
                            state    <= ST_IDLE;
                            rsp_done <= 1'b1;
                        end else begin
                            state <= ST_RDLO;
                        end
                    end
                end
                ST_WAIT: begin
                    if (timer_expired) begin
                        if (polls == PCW'(MAX_POLLS)) begin
                            state   <= ST_IDLE;
                            rsp_err <= 1'b1;
                        end else begin
                            state <= ST_POLL;
                        end
                    end
                end
                ST_RDLO: begin
                    if (mg_done) begin
                        if (cur.wide) begin
                            state <= ST_RDHI;
                        end else begin
                            state    <= ST_IDLE;
                            rsp_done <= 1'b1;
                        end
                    end
                end
                ST_RDHI: begin
                    if (mg_done) begin
                        state    <= ST_IDLE;
                        rsp_done <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/swreg_indirect_access.sv
module swreg_indirect_access
    import swacc_pkg::*;
#(
    parameter int         CYC_PER_US = 250,
    parameter int         WAIT_US    = 10,
    parameter int         MAX_POLLS  = 5,
    parameter logic [4:0] PHY_ADDR   = 5'h1E
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [7:0]  req_page,
    input  logic [7:0]  req_reg,
    input  logic        req_write,
    input  logic        req_wide,
    output logic        req_ack,
    output logic        rsp_done,
    output logic        rsp_err,
    output logic [31:0] rsp_data,
    output logic        mg_valid,
    output logic        mg_write,
    output logic [4:0]  mg_phy,
    output logic [4:0]  mg_regnum,
    output logic [15:0] mg_wdata,
    input  logic        mg_done,
    input  logic [15:0] mg_rdata
);

    localparam int WAIT_CYC = CYC_PER_US * WAIT_US;

    acc_req_t          req_in;
    mg_txn_t           txn;
    logic              page_hit;
    logic              cache_upd;
    logic [PAGE_W-1:0] cache_page;
    logic              timer_start;
    logic              timer_expired;
    logic              cap_clr;
    logic              cap_lo;
    logic              cap_hi;
    logic              busy_bits;

    assign req_in    = '{page: req_page, regn: req_reg, is_write: req_write, wide: req_wide};
    assign busy_bits = cmd_busy(mg_rdata);

    swacc_page_cache #(
        .RESET_PAGE (PAGE_AFTER_RESET)
    ) u_cache (
        .clk        (clk),
        .rst        (rst),
        .probe_page (req_page),
        .upd        (cache_upd),
        .upd_page   (cache_page),
        .hit        (page_hit)
    );

    swacc_wait_timer #(
        .WAIT_CYC (WAIT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (timer_start),
        .expired (timer_expired)
    );

    swacc_sequencer #(
        .MAX_POLLS (MAX_POLLS)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_in        (req_in),
        .req_ack       (req_ack),
        .page_hit      (page_hit),
        .cache_upd     (cache_upd),
        .cache_page    (cache_page),
        .timer_start   (timer_start),
        .timer_expired (timer_expired),
        .mg_valid      (mg_valid),
        .mg_txn        (txn),
        .mg_done       (mg_done),
        .mg_busy       (busy_bits),
        .cap_clr       (cap_clr),
        .cap_lo        (cap_lo),
        .cap_hi        (cap_hi),
        .rsp_done      (rsp_done),
        .rsp_err       (rsp_err)
    );

    swacc_rdata_collect #(
        .HALF_W (MDW)
    ) u_collect (
        .clk    (clk),
        .rst    (rst),
        .clr    (cap_clr),
        .cap_lo (cap_lo),
        .cap_hi (cap_hi),
        .din    (mg_rdata),
        .dout   (rsp_data)
    );

    assign mg_write  = txn.wr;
    assign mg_regnum = txn.regnum;
    assign mg_wdata  = txn.wdata;
    assign mg_phy    = PHY_ADDR;

endmodule

// File: rtl/swacc_checker.sv
module swacc_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_ack,
    input logic        rsp_done,
    input logic        rsp_err,
    input logic [31:0] rsp_data,
    input logic        mg_valid,
    input logic        mg_write,
    input logic [4:0]  mg_regnum,
    input logic [15:0] mg_wdata,
    input logic        mg_done
);

    a_r2_page_word: assert property (@(posedge clk) disable iff (rst)
        (mg_valid && mg_write && mg_regnum == 5'h10) |-> (mg_wdata[7:0] == 8'h01));

    a_r4_cmd_word: assert property (@(posedge clk) disable iff (rst)
        (mg_valid && mg_write && mg_regnum == 5'h11) |->
        (mg_wdata[7:2] == 6'b0 && (mg_wdata[1:0] == 2'b01 || mg_wdata[1:0] == 2'b10)));

    a_r5_read_targets: assert property (@(posedge clk) disable iff (rst)
        (mg_valid && !mg_write) |->
        (mg_regnum == 5'h11 || mg_regnum == 5'h18 || mg_regnum == 5'h19));

    a_r6_err_no_data: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_data == 32'h0));

    a_r10_ack_idle: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> !mg_valid);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    a_r10_err_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_err |=> !rsp_err);

    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rsp_done && rsp_err));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (mg_valid && !mg_done) |=>
        (mg_valid && $stable(mg_write) && $stable(mg_regnum) && $stable(mg_wdata)));

endmodule

bind swreg_indirect_access swacc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ack   (req_ack),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err),
    .rsp_data  (rsp_data),
    .mg_valid  (mg_valid),
    .mg_write  (mg_write),
    .mg_regnum (mg_regnum),
    .mg_wdata  (mg_wdata),
    .mg_done   (mg_done)
);

// File: tb/tb_swreg_indirect_access.sv
`timescale 1ns/1ps
module tb_swreg_indirect_access;

    localparam int CPU   = 4;
    localparam int WUS   = 10;
    localparam int WCYC  = CPU * WUS;
    localparam int LAT   = 2;
    localparam int LOGN  = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [7:0]  req_page = '0;
    logic [7:0]  req_reg = '0;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic        req_ack;
    logic        rsp_done;
    logic        rsp_err;
    logic [31:0] rsp_data;
    logic        mg_valid;
    logic        mg_write;
    logic [4:0]  mg_phy;
    logic [4:0]  mg_regnum;
    logic [15:0] mg_wdata;
    logic        mg_done = 1'b0;
    logic [15:0] mg_rdata = '0;

    swreg_indirect_access #(
        .CYC_PER_US (CPU),
        .WAIT_US    (WUS),
        .MAX_POLLS  (5),
        .PHY_ADDR   (5'h1E)
    ) dut (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_page (req_page), .req_reg (req_reg),
        .req_write (req_write), .req_wide (req_wide), .req_ack (req_ack),
        .rsp_done (rsp_done), .rsp_err (rsp_err), .rsp_data (rsp_data),
        .mg_valid (mg_valid), .mg_write (mg_write), .mg_phy (mg_phy),
        .mg_regnum (mg_regnum), .mg_wdata (mg_wdata),
        .mg_done (mg_done), .mg_rdata (mg_rdata)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int tests = 0;
    int fails = 0;

    // management model state
    int          busy_left = 0;
    logic [15:0] val_lo = '0;
    logic [15:0] val_hi = '0;
    int          log_n = 0;
    int          mk;
    logic [4:0]  log_phy [LOGN];
    logic [4:0]  log_reg [LOGN];
    logic        log_wr  [LOGN];
    logic [15:0] log_wd  [LOGN];
    int          log_vc  [LOGN];
    int          log_dc  [LOGN];

    initial begin
        forever begin
            @(negedge clk);
            if (mg_valid) begin
                mk = log_n;
                if (mk < LOGN) begin
                    log_phy[mk] = mg_phy;
                    log_reg[mk] = mg_regnum;
                    log_wr[mk]  = mg_write;
                    log_wd[mk]  = mg_wdata;
                    log_vc[mk]  = cyc;
                end
                repeat (LAT - 1) @(negedge clk);
                if (!mg_write && mg_regnum == 5'h11) begin
                    if (busy_left > 0) begin
                        busy_left = busy_left - 1;
                        mg_rdata = 16'h0002;
                    end else begin
                        mg_rdata = 16'h0000;
                    end
                end else if (!mg_write && mg_regnum == 5'h18) begin
                    mg_rdata = val_lo;
                end else if (!mg_write && mg_regnum == 5'h19) begin
                    mg_rdata = val_hi;
                end else begin
                    mg_rdata = 16'h0000;
                end
                mg_done = 1'b1;
                if (mk < LOGN) log_dc[mk] = cyc;
                @(negedge clk);
                mg_done = 1'b0;
                log_n = log_n + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_txn(input int i, input bit wr, input logic [4:0] rg,
                           input logic [15:0] wd, input string tag);
        chk(log_wr[i] == wr && log_reg[i] == rg && (!wr || log_wd[i] == wd), tag,
            {log_wr[i], 3'b0, log_reg[i], log_wd[i]}, {wr, 3'b0, rg, wd});
    endtask

    task automatic chk_phy(input string tag);
        int bad = 0;
        for (int i = 0; i < log_n && i < LOGN; i++)
            if (log_phy[i] != 5'h1E) bad++;
        chk(bad == 0, tag, bad, 0);
    endtask

    logic        r_done, r_err;
    logic [31:0] r_data;

    task automatic do_req(input logic [7:0] pg, input logic [7:0] rg, input bit wr,
                          input bit wd, input int busy, input logic [15:0] lo,
                          input logic [15:0] hi);
        busy_left = busy; val_lo = lo; val_hi = hi; log_n = 0;
        @(negedge clk);
        req_page = pg; req_reg = rg; req_write = wr; req_wide = wd; req_valid = 1'b1;
        #1;
        while (!req_ack) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
        while (!(rsp_done || rsp_err)) @(negedge clk);
        r_done = rsp_done; r_err = rsp_err; r_data = rsp_data;
        @(negedge clk);
        chk(!rsp_done && !rsp_err, "R10 response pulse is one cycle", {rsp_done, rsp_err}, 0);
    endtask

    task automatic t_reset;
        chk(!mg_valid && !rsp_done && !rsp_err && !req_ack && rsp_data == 0,
            "R10 idle after reset", {mg_valid, rsp_done, rsp_err, req_ack}, 0);
    endtask

    task automatic t_first_read16;
        do_req(8'h03, 8'h20, 1'b0, 1'b0, 0, 16'hBEEF, 16'h0);
        chk(log_n == 4, "R3 first access count", log_n, 4);
        chk_txn(0, 1, 5'h10, 16'h0301, "R2 page select word");
        chk_txn(1, 1, 5'h11, 16'h2002, "R4 read command word");
        chk_txn(2, 0, 5'h11, 16'h0, "R5 poll after command");
        chk_txn(3, 0, 5'h18, 16'h0, "R7 low data read");
        chk(r_done && !r_err && r_data == 32'h0000BEEF, "R7 16-bit result", r_data, 32'h0000BEEF);
        chk_phy("R1 pseudo-PHY address");
    endtask

    task automatic t_same_page32;
        do_req(8'h03, 8'h24, 1'b0, 1'b1, 0, 16'h1111, 16'h2222);
        chk(log_n == 4, "R3 same page skips select", log_n, 4);
        chk_txn(0, 1, 5'h11, 16'h2402, "R4 command first when page cached");
        chk_txn(2, 0, 5'h18, 16'h0, "R8 low half read");
        chk_txn(3, 0, 5'h19, 16'h0, "R8 high half read");
        chk(r_done && r_data == 32'h22221111, "R8 32-bit result", r_data, 32'h22221111);
    endtask

    task automatic t_write_newpage;
        do_req(8'h05, 8'h3C, 1'b1, 1'b0, 0, 16'hAAAA, 16'hBBBB);
        chk(log_n == 3, "R9 write has no data read", log_n, 3);
        chk_txn(0, 1, 5'h10, 16'h0501, "R3 page change writes select");
        chk_txn(1, 1, 5'h11, 16'h3C01, "R4 write command word");
        chk(r_done && !r_err && r_data == 0, "R9 write response", r_data, 0);
        chk_phy("R1 pseudo-PHY address write");
    endtask

    task automatic t_busy_polls;
        int bad = 0;
        do_req(8'h05, 8'h10, 1'b0, 1'b0, 2, 16'h00A5, 16'h0);
        chk(log_n == 5, "R5 three polls then data", log_n, 5);
        for (int i = 1; i < 3; i++) begin
            int gap = log_vc[i + 1] - log_dc[i];
            if (gap < WCYC || gap > WCYC + 4) bad++;
            if (log_reg[i + 1] != 5'h11 || log_wr[i + 1]) bad++;
        end
        chk(bad == 0, "R5 wait between busy polls", bad, 0);
        chk_txn(4, 0, 5'h18, 16'h0, "R5 data read after clear");
        chk(r_done && r_data == 32'h000000A5, "R7 result after polling", r_data, 32'hA5);
    endtask

    task automatic t_timeout;
        int npoll = 0;
        int ndata = 0;
        do_req(8'h05, 8'h11, 1'b0, 1'b1, 100, 16'h5555, 16'h6666);
        for (int i = 0; i < log_n; i++) begin
            if (!log_wr[i] && log_reg[i] == 5'h11) npoll++;
            if (log_reg[i] == 5'h18 || log_reg[i] == 5'h19) ndata++;
        end
        chk(npoll == 5, "R6 poll limit", npoll, 5);
        chk(ndata == 0, "R6 no data read on timeout", ndata, 0);
        chk(r_err && !r_done && r_data == 0, "R6 error flag and zero data",
            {r_err, r_done, r_data}, {1'b1, 1'b0, 32'h0});
    endtask

    task automatic t_held_request;
        int a1, early = 0;
        busy_left = 0; val_lo = 16'h7777; log_n = 0;
        @(negedge clk);
        req_page = 8'h05; req_reg = 8'h01; req_write = 1'b0; req_wide = 1'b0; req_valid = 1'b1;
        #1;
        while (!req_ack) begin @(negedge clk); #1; end
        a1 = cyc;
        forever begin
            @(negedge clk);
            if (rsp_done || rsp_err) break;
            if (req_ack) early++;
        end
        chk(early == 0, "R10 no ack while busy", early, 0);
        chk(req_ack == 1'b1, "R10 held request acked at completion", req_ack, 1);
        chk(rsp_data == 32'h7777 && cyc > a1, "R7 first held result", rsp_data, 32'h7777);
        @(negedge clk);
        req_valid = 1'b0;
        while (!(rsp_done || rsp_err)) @(negedge clk);
        chk(rsp_done && log_n == 6, "R3 second held request same page", log_n, 6);
    endtask

    task automatic t_reset_cache;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        do_req(8'hFF, 8'h02, 1'b0, 1'b0, 0, 16'h0F0F, 16'h0);
        chk(log_n == 3, "R3 reset page FF needs no select", log_n, 3);
        chk_txn(0, 1, 5'h11, 16'h0202, "R4 command first after reset on page FF");
        chk(r_done && r_data == 32'h0F0F, "R7 result page FF", r_data, 32'h0F0F);
        do_req(8'h00, 8'h02, 1'b0, 1'b0, 0, 16'h1234, 16'h0);
        chk_txn(0, 1, 5'h10, 16'h0001, "R2 select for page 00");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_first_read16();
        t_same_page32();
        t_write_newpage();
        t_busy_polls();
        t_timeout();
        t_held_request();
        t_reset_cache();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule